// File: doc/BRIEF.md
# Event Interrupt and Keyed Reset Unit

This block sits beside a serial-peripheral controller and turns its one-cycle event pulses into a sticky interrupt status word. Software sees four locations through a 32-bit register port:

- a master interrupt gate;
- the status word;
- a per-source mask;
- a reset trigger.

A single level interrupt line is raised when the gate is open and at least one latched, unmasked source is present. Status bits are cleared by writing ones to them. A handler can therefore read the status word and write the same value back to acknowledge exactly what it saw, while any event arriving in the same cycle is kept.

The reset trigger is keyed. Only the exact 32-bit value 0x0000000A written to it starts a reset pulse, which lasts several clocks. That pulse resets the attached peripheral and also wipes the status, mask and gate registers of this unit. Every other value written there is dropped.

Top module: `evt_irq_unit`

## Requirements
- R1: While `rst` is high and after it falls, status, mask and gate read as zero, and `irq_o`, `periph_rst_o` and `rdata` are 0.
- R2: A one-cycle pulse on `evt[i]` sets status bit i, and the bit stays set until cleared. The source order is: bit 0 master fault, bit 1 slave-select fault, bit 2 transmit queue empty, bit 3 transmit underrun, bit 4 receive full, bit 5 receive overrun, bit 6 transmit half empty.
- R3: A write to byte offset 0x20 clears each status bit whose `wdata` bit is 1. Bits written with 0 are unchanged.
- R4: When an event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The mask register at offset 0x28 stores `wdata[6:0]`. It reads back in bits 6:0, and bits 31:7 read as 0.
- R6: The gate is bit 31 at offset 0x1C and reads back in bit 31. While it is 0, `irq_o` stays 0.
- R7: `irq_o` equals gate AND OR(status AND mask) as held in the previous cycle, which is one register stage.
- R8: With the mask at zero, events still latch into status, and `irq_o` stays 0.
- R9: Writing 0x0000000A to offset 0x40 drives `periph_rst_o` high for exactly RST_LEN cycles, starting the cycle after the write.
- R10: Writing any other value to offset 0x40 leaves `periph_rst_o` low and all registers unchanged.
- R11: During the reset pulse, status, mask and gate are cleared. Events and register writes arriving during the pulse are discarded.
- R12: `rdata` is registered and shows the register addressed in the previous cycle. Offset 0x40 and any unmapped offset read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's `addr` |
| evt | input | NSRC | One-cycle event pulses from the peripheral |
| irq_o | output | 1 | Level interrupt request |
| periph_rst_o | output | 1 | Reset pulse to the peripheral |

## Verification
The bench builds the unit with its default parameters: seven sources, 8-bit offsets and RST_LEN of 4. With these values every source bit, all four offsets and the full width of the reset pulse can be reached in a few cycles. A short pulse also lets the bench land an event and a write inside the pulse window and count its exact length. With eight address bits the bench can probe offsets outside the map, and it applies near-miss key values to the reset location.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int DATA_W = 32;
  localparam int GATE_BIT = 31;

  localparam logic [7:0] OFS_GATE = 8'h1C;
  localparam logic [7:0] OFS_STAT = 8'h20;
  localparam logic [7:0] OFS_MASK = 8'h28;
  localparam logic [7:0] OFS_KICK = 8'h40;

  localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_000A;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_GATE,
    SEL_STAT,
    SEL_MASK,
    SEL_KICK
  } reg_sel_e;
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wipe,
  input  logic [NSRC-1:0] evt,
  input  logic [NSRC-1:0] ack_mask,
  output logic [NSRC-1:0] stat
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || wipe)   stat[i] <= 1'b0;
      else if (evt[i])   stat[i] <= 1'b1;
      else if (ack_mask[i]) stat[i] <= 1'b0;
    end
  end

  AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    wipe |=> (stat == '0)); // R11
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (!wipe && ((evt & ack_mask) != '0)) |=>
      ((stat & $past(evt & ack_mask)) == $past(evt & ack_mask))); // R4
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!wipe && evt == '0 && ack_mask == '0) |=> $stable(stat)); // R2
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
  parameter int NSRC = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gate,
  input  logic [NSRC-1:0] stat,
  input  logic [NSRC-1:0] mask,
  output logic            irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= gate && ((stat & mask) != '0);
  end

  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (rst)
    !gate |=> !irq_o); // R6
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((stat & mask) == '0) |=> !irq_o); // R8
endmodule

// File: rtl/keyed_reset_pulser.sv
module keyed_reset_pulser
  import evt_irq_pkg::*;
#(
  parameter int RST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kick_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              pulse_o
);
  localparam int CNT_W = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             key_hit;

  assign key_hit = kick_wr && (wdata == KICK_KEY);

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (key_hit)        cnt_q <= CNT_W'(RST_LEN);
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign pulse_o = (cnt_q != '0);

  AST_KEY_FIRES: assert property (@(posedge clk) disable iff (rst)
    key_hit |=> pulse_o); // R9
  AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $past(key_hit)); // R10
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NSRC    = 7,
  parameter int RST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NSRC-1:0]   evt,
  output logic              irq_o,
  output logic              periph_rst_o
);
  localparam int PAD_W = DATA_W - NSRC;

  reg_sel_e        sel;
  logic [NSRC-1:0] stat;
  logic [NSRC-1:0] mask_q;
  logic            gate_q;
  logic [NSRC-1:0] ack_mask;
  logic            soft_busy;

  always_comb begin
    sel = SEL_NONE;
    if      (addr == ADDR_W'(OFS_GATE)) sel = SEL_GATE;
    else if (addr == ADDR_W'(OFS_STAT)) sel = SEL_STAT;
    else if (addr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
    else if (addr == ADDR_W'(OFS_KICK)) sel = SEL_KICK;
  end

  assign ack_mask = (wr_en && sel == SEL_STAT) ? wdata[NSRC-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst || soft_busy) begin
      mask_q <= '0;
      gate_q <= 1'b0;
    end else if (wr_en) begin
      if (sel == SEL_MASK) mask_q <= wdata[NSRC-1:0];
      if (sel == SEL_GATE) gate_q <= wdata[GATE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      unique case (sel)
        SEL_GATE: rdata <= {gate_q, {(DATA_W-1){1'b0}}};
        SEL_STAT: rdata <= {{PAD_W{1'b0}}, stat};
        SEL_MASK: rdata <= {{PAD_W{1'b0}}, mask_q};
        default:  rdata <= '0;
      endcase
    end
  end

  evt_status_bank #(.NSRC(NSRC)) u_stat (
    .clk(clk), .rst(rst), .wipe(soft_busy),
    .evt(evt), .ack_mask(ack_mask), .stat(stat)
  );

  irq_merge #(.NSRC(NSRC)) u_merge (
    .clk(clk), .rst(rst), .gate(gate_q),
    .stat(stat), .mask(mask_q), .irq_o(irq_o)
  );

  keyed_reset_pulser #(.RST_LEN(RST_LEN)) u_kick (
    .clk(clk), .rst(rst), .kick_wr(wr_en && sel == SEL_KICK),
    .wdata(wdata), .pulse_o(soft_busy)
  );

  assign periph_rst_o = soft_busy;

  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    soft_busy |=> (mask_q == '0 && !gate_q)); // R11
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sel == SEL_NONE || sel == SEL_KICK) |=> (rdata == '0)); // R12
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!irq_o && rdata == '0 && !periph_rst_o)); // R1
endmodule

// File: tb/evt_irq_unit_tb.sv
module evt_irq_unit_tb;
  localparam int RST_LEN = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = 32'h0;
  logic [6:0]  evt = 7'h0;
  logic [31:0] rdata;
  logic        irq_o, periph_rst_o;

  int vectors = 0;
  int misses = 0;
  bit cmp_on = 1'b0;
  bit finished = 1'b0;
  string tag = "R1";

  // behavioural reference state
  logic [6:0]  m_stat = '0, m_en = '0;
  logic        m_gie = 1'b0, m_irq = 1'b0;
  logic [31:0] m_rdata = '0;
  int          m_cnt = 0;

  evt_irq_unit #(.ADDR_W(8), .NSRC(7), .RST_LEN(RST_LEN)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .evt(evt), .irq_o(irq_o), .periph_rst_o(periph_rst_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) begin
      m_stat <= '0; m_en <= '0; m_gie <= 1'b0; m_irq <= 1'b0;
      m_rdata <= '0; m_cnt <= 0;
    end else begin
      case (addr)
        8'h1C:   m_rdata <= {m_gie, 31'b0};
        8'h20:   m_rdata <= {25'b0, m_stat};
        8'h28:   m_rdata <= {25'b0, m_en};
        default: m_rdata <= '0;
      endcase
      m_irq <= m_gie && ((m_stat & m_en) != 0);
      if (wr_en && addr == 8'h40 && wdata == 32'hA) m_cnt <= RST_LEN;
      else if (m_cnt > 0) m_cnt <= m_cnt - 1;
      if (m_cnt > 0) begin
        m_stat <= '0; m_en <= '0; m_gie <= 1'b0;
      end else begin
        m_stat <= (m_stat & ~((wr_en && addr == 8'h20) ? wdata[6:0] : 7'h0)) | evt;
        if (wr_en && addr == 8'h28) m_en <= wdata[6:0];
        if (wr_en && addr == 8'h1C) m_gie <= wdata[31];
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      vectors++;
      if (rdata !== m_rdata || irq_o !== m_irq || periph_rst_o !== (m_cnt > 0)) begin
        misses++;
        $display("FAIL %s: rdata=%h irq=%b rst=%b expected rdata=%h irq=%b rst=%b",
                 tag, rdata, irq_o, periph_rst_o, m_rdata, m_irq, (m_cnt > 0));
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got %h expected %h", t, got, exp);
    end
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [6:0] e);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; evt = e;
  endtask

  task automatic rd(input string t, input logic [7:0] a, input logic [31:0] exp);
    step(1'b0, a, 32'h0, 7'h0);
    @(negedge clk);
    chk(t, rdata, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int n;
    addr = 8'h20;
    repeat (3) @(posedge clk);
    cmp_on = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 periph_rst", {31'b0, periph_rst_o}, 32'h0);
    rd("R1 mask", 8'h28, 32'h0);
    rd("R1 gate", 8'h1C, 32'h0);

    tag = "R5";
    step(1'b1, 8'h28, 32'h0000_0055, 7'h0);
    rd("R5 mask 55", 8'h28, 32'h55);
    step(1'b1, 8'h28, 32'hFFFF_FFFF, 7'h0);
    rd("R5 mask upper zero", 8'h28, 32'h7F);
    step(1'b1, 8'h28, 32'h0, 7'h0);

    tag = "R8";
    step(1'b1, 8'h1C, 32'h8000_0000, 7'h0);
    for (int i = 0; i < 7; i++) step(1'b0, 8'h00, 32'h0, 7'(1 << i));
    step(1'b0, 8'h00, 32'h0, 7'h0);
    rd("R2 all sources latched", 8'h20, 32'h7F);
    chk("R8 masked irq", {31'b0, irq_o}, 32'h0);
    rd("R6 gate readback", 8'h1C, 32'h8000_0000);

    tag = "R3";
    step(1'b1, 8'h20, 32'h0000_0005, 7'h0);
    rd("R3 w1c", 8'h20, 32'h7A);

    tag = "R7";
    step(1'b1, 8'h28, 32'h0000_0002, 7'h0);
    step(1'b0, 8'h00, 32'h0, 7'h0);
    step(1'b0, 8'h00, 32'h0, 7'h0);
    @(negedge clk);
    chk("R7 irq raised", {31'b0, irq_o}, 32'h1);
    step(1'b1, 8'h20, 32'h0000_0002, 7'h0);
    step(1'b0, 8'h00, 32'h0, 7'h0);
    step(1'b0, 8'h00, 32'h0, 7'h0);
    @(negedge clk);
    chk("R7 irq dropped", {31'b0, irq_o}, 32'h0);
    rd("R7 status after ack", 8'h20, 32'h78);

    tag = "R4";
    step(1'b1, 8'h20, 32'h0000_0018, 7'h08);
    rd("R4 set wins", 8'h20, 32'h68);

    tag = "R6";
    step(1'b1, 8'h28, 32'h0000_0068, 7'h0);
    step(1'b1, 8'h1C, 32'h0, 7'h0);
    step(1'b0, 8'h00, 32'h0, 7'h0);
    step(1'b0, 8'h00, 32'h0, 7'h0);
    @(negedge clk);
    chk("R6 gate closed", {31'b0, irq_o}, 32'h0);
    step(1'b1, 8'h1C, 32'h8000_0000, 7'h0);
    step(1'b0, 8'h00, 32'h0, 7'h0);
    step(1'b0, 8'h00, 32'h0, 7'h0);
    @(negedge clk);
    chk("R7 gate open", {31'b0, irq_o}, 32'h1);

    tag = "R12";
    rd("R12 unmapped", 8'h30, 32'h0);
    rd("R12 kick reads zero", 8'h40, 32'h0);

    tag = "R10";
    step(1'b1, 8'h40, 32'h0000_000B, 7'h0);
    step(1'b1, 8'h40, 32'h0000_0A00, 7'h0);
    step(1'b1, 8'h40, 32'h8000_000A, 7'h0);
    step(1'b0, 8'h00, 32'h0, 7'h0);
    @(negedge clk);
    chk("R10 no pulse", {31'b0, periph_rst_o}, 32'h0);
    rd("R10 status kept", 8'h20, 32'h68);

    tag = "R9";
    step(1'b1, 8'h40, 32'h0000_000A, 7'h0);
    n = 0;
    for (int i = 0; i < RST_LEN + 3; i++) begin
      @(negedge clk);
      if (periph_rst_o) n++;
      if (i == 1) begin wr_en = 1'b1; addr = 8'h28; wdata = 32'h7F; evt = 7'h01; end
      else begin wr_en = 1'b0; addr = 8'h00; wdata = 32'h0; evt = 7'h0; end
    end
    chk("R9 pulse width", n, RST_LEN);
    tag = "R11";
    rd("R11 status wiped", 8'h20, 32'h0);
    rd("R11 mask wiped", 8'h28, 32'h0);
    rd("R11 gate wiped", 8'h1C, 32'h0);

    tag = "R2";
    step(1'b0, 8'h00, 32'h0, 7'h10);
    rd("R2 latch after pulse", 8'h20, 32'h10);
    repeat (3) step(1'b0, 8'h00, 32'h0, 7'h0);

    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule